// File: doc/BRIEF.md
# Three-Key Sequence Door Lock

This block is a clocked Moore state machine that sits behind a two-key keypad and opens a door when the keys B, A, B are entered in that order. On every rising clock edge it samples a strobe that marks a keypress and two lines that say which key it was. The inputs are assumed to be synchronous, debounced single-cycle strobes already. Keypad scanning and the display decoder are not part of this block.

The machine counts each accepted key on a 4-bit bus that drives a display decoder. A wrong key does not end the attempt early. The machine moves onto a separate set of error states and keeps counting, so an intruder learns nothing until all three keys are in. After the third key, the machine spends exactly one cycle in a grant state or a deny state and then returns to idle. The grant state raises a single-cycle release pulse. Both outputs are decoded from the state register alone.

Top module: `code_lock_fsm`

## Requirements
- R1: A synchronous active-high reset puts the machine in idle, with release_pulse low and keys_shown equal to 0 in the cycle after the reset edge.
- R2: A key is accepted only when key_valid is 1 and exactly one of key_is_a and key_is_b is 1. key_is_a=1 means key A and key_is_b=1 means key B.
- R3: A cycle with no accepted key leaves the state unchanged. This covers key_valid=0, and key_valid=1 with both key lines high or both low.
- R4: Each accepted key from idle or from a one-key or two-key state raises keys_shown by exactly one. The new value shows after that clock edge, so the display reads 1, 2 and then 3.
- R5: The ordered sequence B, A, B raises release_pulse in the cycle after the third key, with keys_shown equal to 3.
- R6: Any three accepted keys that are not B, A, B give keys_shown equal to 3 with release_pulse low. A wrong key is not rejected before the third key: the count keeps rising 1, 2, 3.
- R7: The grant state and the deny state each last one cycle. The next state is idle, with keys_shown 0 and release_pulse low. A key presented during that cycle is ignored.
- R8: release_pulse is never high for two cycles in a row, and it is high only when keys_shown is 3.
- R9: The outputs depend only on the state register. Changing the inputs between clock edges does not change the outputs.
- R10: keys_shown never exceeds 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | A key strobe is present this cycle |
| key_is_a | input | 1 | Identifies key A |
| key_is_b | input | 1 | Identifies key B |
| release_pulse | output | 1 | One-cycle door release |
| keys_shown | output | COUNT_W (4) | Keys entered in the current attempt |

## Verification
Because both outputs come straight from the state register, a wrong state shows up on the ports in the first cycle after the edge that caused it. Two kinds of wrong state behave differently. Mixing up a correct-path state with its error-path twin shows the same count, so it stays hidden until the third key, when the release pulse appears or fails to appear. A wrong count appears at once on keys_shown. The directed tests therefore run every position of a wrong key through to the final verdict. They also check the count after every single key, not only at the end of an attempt.

// File: rtl/lock_pkg.sv
package lock_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OK1   = 3'd1,
        ST_OK2   = 3'd2,
        ST_BAD1  = 3'd3,
        ST_BAD2  = 3'd4,
        ST_GRANT = 3'd5,
        ST_DENY  = 3'd6
    } lock_state_e;

    typedef struct packed {
        lock_state_e state;
    } lock_regs_t;

    localparam lock_regs_t LOCK_RESET = '{state: ST_IDLE};

endpackage

// File: rtl/lock_key_decode.sv
module lock_key_decode (
    input  logic key_valid,
    input  logic key_is_a,
    input  logic key_is_b,
    output logic hit_a,
    output logic hit_b
);
    logic single_line;

    always_comb begin
        single_line = key_is_a ^ key_is_b;
        hit_a       = key_valid && single_line && key_is_a;
        hit_b       = key_valid && single_line && key_is_b;
    end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
    import lock_pkg::*;
(
    input  lock_regs_t cur_q,
    input  logic       hit_a,
    input  logic       hit_b,
    output lock_regs_t nxt_d
);
    logic any_hit;

    always_comb begin
        any_hit = hit_a || hit_b;
        nxt_d   = cur_q;
        case (cur_q.state)
            ST_IDLE: begin
                if (hit_b)      nxt_d.state = ST_OK1;
                else if (hit_a) nxt_d.state = ST_BAD1;
            end
            ST_OK1: begin
                if (hit_a)      nxt_d.state = ST_OK2;
                else if (hit_b) nxt_d.state = ST_BAD2;
            end
            ST_OK2: begin
                if (hit_b)      nxt_d.state = ST_GRANT;
                else if (hit_a) nxt_d.state = ST_DENY;
            end
            ST_BAD1: begin
                if (any_hit) nxt_d.state = ST_BAD2;
            end
            ST_BAD2: begin
                if (any_hit) nxt_d.state = ST_DENY;
            end
            ST_GRANT, ST_DENY: nxt_d.state = ST_IDLE;
            default:           nxt_d.state = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/lock_output_decode.sv
module lock_output_decode
    import lock_pkg::*;
#(
    parameter int COUNT_W = 4
) (
    input  lock_regs_t         cur_q,
    output logic               release_pulse,
    output logic [COUNT_W-1:0] keys_shown
);
    always_comb begin
        release_pulse = (cur_q.state == ST_GRANT);
        case (cur_q.state)
            ST_OK1, ST_BAD1:   keys_shown = COUNT_W'(1);
            ST_OK2, ST_BAD2:   keys_shown = COUNT_W'(2);
            ST_GRANT, ST_DENY: keys_shown = COUNT_W'(3);
            default:           keys_shown = '0;
        endcase
    end
endmodule

// File: rtl/code_lock_fsm.sv
module code_lock_fsm
    import lock_pkg::*;
#(
    parameter int COUNT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               key_valid,
    input  logic               key_is_a,
    input  logic               key_is_b,
    output logic               release_pulse,
    output logic [COUNT_W-1:0] keys_shown
);
    lock_regs_t regs_q;
    lock_regs_t regs_d;
    lock_regs_t step_d;
    logic       hit_a;
    logic       hit_b;

    lock_key_decode i_decode (
        .key_valid (key_valid),
        .key_is_a  (key_is_a),
        .key_is_b  (key_is_b),
        .hit_a     (hit_a),
        .hit_b     (hit_b)
    );

    lock_next_state i_next (
        .cur_q (regs_q),
        .hit_a (hit_a),
        .hit_b (hit_b),
        .nxt_d (step_d)
    );

    always_comb begin
        regs_d = rst ? LOCK_RESET : step_d;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    lock_output_decode #(.COUNT_W(COUNT_W)) i_out (
        .cur_q         (regs_q),
        .release_pulse (release_pulse),
        .keys_shown    (keys_shown)
    );
endmodule

// File: rtl/code_lock_fsm_checker.sv
module code_lock_fsm_checker #(
    parameter int COUNT_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               key_valid,
    input logic               key_is_a,
    input logic               key_is_b,
    input logic               release_pulse,
    input logic [COUNT_W-1:0] keys_shown
);
    logic accepted;
    assign accepted = key_valid && (key_is_a ^ key_is_b);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (keys_shown == '0 && !release_pulse));

    p_hold_without_key_r3: assert property (@(posedge clk) disable iff (rst)
        (!accepted && keys_shown != COUNT_W'(3)) |=> $stable(keys_shown));

    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        (accepted && keys_shown < COUNT_W'(3)) |=> keys_shown == $past(keys_shown) + COUNT_W'(1));

    p_verdict_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        keys_shown == COUNT_W'(3) |=> (keys_shown == '0 && !release_pulse));

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
        release_pulse |=> !release_pulse);

    p_pulse_at_three_r8: assert property (@(posedge clk) disable iff (rst)
        release_pulse |-> keys_shown == COUNT_W'(3));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
        keys_shown <= COUNT_W'(3));
endmodule

bind code_lock_fsm code_lock_fsm_checker #(.COUNT_W(COUNT_W)) i_checker (
    .clk           (clk),
    .rst           (rst),
    .key_valid     (key_valid),
    .key_is_a      (key_is_a),
    .key_is_b      (key_is_b),
    .release_pulse (release_pulse),
    .keys_shown    (keys_shown)
);

// File: tb/test_code_lock_fsm.sv
`timescale 1ns/1ps
module test_code_lock_fsm;
    localparam int COUNT_W = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               key_valid = 1'b0;
    logic               key_is_a = 1'b0;
    logic               key_is_b = 1'b0;
    logic               release_pulse;
    logic [COUNT_W-1:0] keys_shown;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    code_lock_fsm #(.COUNT_W(COUNT_W)) i_code_lock_fsm (
        .clk           (clk),
        .rst           (rst),
        .key_valid     (key_valid),
        .key_is_a      (key_is_a),
        .key_is_b      (key_is_b),
        .release_pulse (release_pulse),
        .keys_shown    (keys_shown)
    );

    task automatic check(input string req, input int exp_cnt, input logic exp_pulse);
        checks++;
        if (keys_shown !== COUNT_W'(exp_cnt) || release_pulse !== exp_pulse) begin
            errors++;
            $display("FAIL %s: count=%0d pulse=%0b expected count=%0d pulse=%0b",
                     req, keys_shown, release_pulse, exp_cnt, exp_pulse);
        end
    endtask

    // drive inputs at the falling edge, return 2 ns after the rising edge with inputs cleared
    task automatic cycle(input logic v, input logic a, input logic b);
        @(negedge clk);
        key_valid = v; key_is_a = a; key_is_b = b;
        @(posedge clk);
        #2;
        key_valid = 1'b0; key_is_a = 1'b0; key_is_b = 1'b0;
    endtask

    task automatic key_a(); cycle(1'b1, 1'b1, 1'b0); endtask
    task automatic key_b(); cycle(1'b1, 1'b0, 1'b1); endtask
    task automatic idle();  cycle(1'b0, 1'b0, 1'b0); endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 reset state", 0, 1'b0);
    endtask

    task automatic t_good_code();
        key_b(); check("R4 first key", 1, 1'b0);
        key_a(); check("R4 second key", 2, 1'b0);
        key_b(); check("R5 grant after B,A,B", 3, 1'b1);
        idle();  check("R7 back to idle after grant", 0, 1'b0);
        idle();  check("R8 pulse not repeated", 0, 1'b0);
    endtask

    task automatic t_wrong_first();
        key_a(); check("R6 wrong first key still counts", 1, 1'b0);
        key_b(); check("R6 count continues", 2, 1'b0);
        key_b(); check("R6 deny after wrong first", 3, 1'b0);
        idle();  check("R7 idle after deny", 0, 1'b0);
    endtask

    task automatic t_wrong_second();
        key_b(); key_b(); check("R6 wrong second key counts", 2, 1'b0);
        key_b(); check("R6 deny after wrong second", 3, 1'b0);
        idle();
    endtask

    task automatic t_wrong_third();
        key_b(); key_a(); key_a(); check("R6 deny after wrong third", 3, 1'b0);
        idle(); check("R7 idle after deny third", 0, 1'b0);
    endtask

    task automatic t_gaps_and_junk();
        key_b();
        idle();              check("R3 no key holds", 1, 1'b0);
        cycle(1'b1, 1'b1, 1'b1); check("R2 both lines ignored", 1, 1'b0);
        cycle(1'b1, 1'b0, 1'b0); check("R2 no line ignored", 1, 1'b0);
        cycle(1'b0, 1'b1, 1'b0); check("R3 lines without strobe ignored", 1, 1'b0);
        key_a();             check("R4 count after gaps", 2, 1'b0);
        idle(); idle();      check("R3 hold at two", 2, 1'b0);
        key_b();             check("R5 grant after gaps", 3, 1'b1);
        idle();
    endtask

    task automatic t_key_during_verdict();
        key_b(); key_a(); key_b(); check("R5 grant before extra key", 3, 1'b1);
        key_b(); check("R7 key during grant ignored", 0, 1'b0);
        key_a(); key_a(); key_a(); check("R6 deny before extra key", 3, 1'b0);
        key_b(); check("R7 key during deny ignored", 0, 1'b0);
        key_b(); key_a(); key_b(); check("R5 grant right after deny", 3, 1'b1);
        idle();
    endtask

    task automatic t_moore_outputs();
        key_b();
        key_valid = 1'b1; key_is_a = 1'b1; #3;
        check("R9 outputs stable with input mid-cycle", 1, 1'b0);
        key_is_a = 1'b0; key_is_b = 1'b1; #3;
        check("R9 outputs stable on second change", 1, 1'b0);
        key_valid = 1'b0; key_is_b = 1'b0;
        do_reset();
        check("R1 reset mid attempt", 0, 1'b0);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: expected=finish actual=timeout");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_good_code();
        t_wrong_first();
        t_wrong_second();
        t_wrong_third();
        t_gaps_and_junk();
        t_key_during_verdict();
        t_moore_outputs();
        t_good_code();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule